// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block holds the page translations for data accesses. It has 64 entries and is direct-mapped: virtual address bits 18..13 select one entry. Virtual address bits 31..19 are compared against the tag stored in that entry. When the lookup enable is high, the selected entry is compared and its contents are registered. On the next cycle the block shows a hit flag, a 19-bit physical page number, four access-permission bits and a cache-inhibit bit. The surrounding logic joins the page number to virtual address bits 12..0 and turns misses and permission violations into exceptions. That logic sits outside this block.

Software loads and inspects entries through a special-register port. Each entry is split into two halves, and each half has its own 64-word window. The tag half holds the tag and the valid flag. The translation half holds the physical page number, the permissions and the cache-inhibit bit. Only the bits that the entry actually stores are kept. Every other bit reads back as zero.

Top module: `dtlb_top`

## Requirements
- R1: After an active-low reset, every entry is invalid. Any lookup then misses, and a tag-window read shows bit 0 clear.
- R2: A write to offset 0x0A00+n (n = 0..63) stores register bits 31..19 as the tag of entry n and bit 0 as its valid flag. A read at that offset returns the tag in bits 31..19, the valid flag in bit 0, and zero in every other bit.
- R3: A write to offset 0x0B00+n stores, for entry n: the physical page number from bits 31..13, supervisor-write from bit 9, supervisor-read from bit 8, user-write from bit 7, user-read from bit 6 and cache-inhibit from bit 1. A read returns those fields in the same positions and zero in every other bit.
- R4: A lookup uses virtual address bits 18..13 as the entry index. On the cycle after the enable, hit_o is 1 when that entry is valid and its stored tag equals virtual address bits 31..19.
- R5: hit_o is 0 on the cycle after the enable when the indexed entry is invalid or its tag differs.
- R6: While the lookup enable is low, every lookup output holds its value.
- R7: An access is ignored when chip select is low, or when the address has bits outside the entry field that differ from the two windows' base offsets. Address bit 8 selects the window (0 = tag, 1 = translation). An ignored write changes no entry, and an ignored read returns zero.
- R8: With chip select low, the read data is zero.
- R9: On a hit, ppn_o, sw_o, sr_o, uw_o, ur_o and ci_o equal the fields last written to the indexed entry's translation half.
- R10: When a register write and a lookup hit the same entry on the same clock edge, the lookup returns the contents from before the write. The new contents apply from the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_en_i | input | 1 | Starts a lookup of vaddr_i |
| vaddr_i | input | 32 | Virtual address |
| hit_o | output | 1 | Lookup hit, valid the cycle after the enable |
| ppn_o | output | 19 | Physical page number of the indexed entry |
| sw_o | output | 1 | Supervisor write allowed |
| sr_o | output | 1 | Supervisor read allowed |
| uw_o | output | 1 | User write allowed |
| ur_o | output | 1 | User read allowed |
| ci_o | output | 1 | Cache inhibit |
| reg_cs_i | input | 1 | Register port select |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 32 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |

## Verification
A corrupted valid bit or tag shows up at hit_o on the cycle after the enable for the affected index. A corrupted index decode shows up as a hit or miss on the wrong entry when several entries share a tag or a page number. A fault in the register decode or the field packing is visible in the same cycle on reg_rdata_o. A write that aliases to another entry only becomes visible at a later lookup or read-back of that entry, so the bench probes the aliased entry straight after each ignored access.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int unsigned SW_BIT = 9;
  localparam int unsigned SR_BIT = 8;
  localparam int unsigned UW_BIT = 7;
  localparam int unsigned UR_BIT = 6;
  localparam int unsigned CI_BIT = 1;
  localparam int unsigned VALID_BIT = 0;

  typedef struct packed {
    logic sw;
    logic sr;
    logic uw;
    logic ur;
  } perm_t;
endpackage

// File: rtl/dtlb_reg_decode.sv
module dtlb_reg_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W = 6,
  parameter logic [31:0] MATCH_BASE = 32'h0000_0A00,
  parameter logic [31:0] XLATE_BASE = 32'h0000_0B00
) (
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_match_o,
  output logic              sel_xlate_o,
  output logic              wr_match_o,
  output logic              wr_xlate_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'((1 << IDX_W) - 1);

  logic [ADDR_W-1:0] page;
  assign page = addr_i & ~IDX_MASK;

  assign sel_match_o = cs_i && (page == ADDR_W'(MATCH_BASE));
  assign sel_xlate_o = cs_i && (page == ADDR_W'(XLATE_BASE));
  assign wr_match_o  = sel_match_o && we_i;
  assign wr_xlate_o  = sel_xlate_o && we_i;
  assign idx_o       = addr_i[IDX_W-1:0];
endmodule

// File: rtl/dtlb_entry_store.sv
module dtlb_entry_store
  import dtlb_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned TAG_W = 13,
  parameter int unsigned PPN_W = 19,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_match_i,
  input  logic             wr_xlate_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [TAG_W-1:0] wtag_i,
  input  logic             wvalid_i,
  input  logic [PPN_W-1:0] wppn_i,
  input  perm_t            wperm_i,
  input  logic             wci_i,
  // lookup read port
  input  logic [IDX_W-1:0] lidx_i,
  output logic             lvalid_o,
  output logic [TAG_W-1:0] ltag_o,
  output logic [PPN_W-1:0] lppn_o,
  output perm_t            lperm_o,
  output logic             lci_o,
  // register read port
  input  logic [IDX_W-1:0] ridx_i,
  output logic             rvalid_o,
  output logic [TAG_W-1:0] rtag_o,
  output logic [PPN_W-1:0] rppn_o,
  output perm_t            rperm_o,
  output logic             rci_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];
  logic [ENTRIES-1:0] ci_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit_w;
    assign hit_w = (widx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_q[e] <= 1'b0;
      else if (wr_match_i && hit_w) valid_q[e] <= wvalid_i;
    end

    always_ff @(posedge clk_i) begin
      if (wr_match_i && hit_w) tag_q[e] <= wtag_i;
      if (wr_xlate_i && hit_w) begin
        ppn_q[e]  <= wppn_i;
        perm_q[e] <= wperm_i;
        ci_q[e]   <= wci_i;
      end
    end
  end

  assign lvalid_o = valid_q[lidx_i];
  assign ltag_o   = tag_q[lidx_i];
  assign lppn_o   = ppn_q[lidx_i];
  assign lperm_o  = perm_q[lidx_i];
  assign lci_o    = ci_q[lidx_i];

  assign rvalid_o = valid_q[ridx_i];
  assign rtag_o   = tag_q[ridx_i];
  assign rppn_o   = ppn_q[ridx_i];
  assign rperm_o  = perm_q[ridx_i];
  assign rci_o    = ci_q[ridx_i];
endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
  import dtlb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned PPN_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:OFF_W] vpage_i,
  output logic [IDX_W-1:0]  idx_o,
  input  logic              evalid_i,
  input  logic [TAG_W-1:0]  etag_i,
  input  logic [PPN_W-1:0]  eppn_i,
  input  perm_t             eperm_i,
  input  logic              eci_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output perm_t             perm_o,
  output logic              ci_o
);
  logic [TAG_W-1:0] vtag;
  assign idx_o = vpage_i[OFF_W+IDX_W-1:OFF_W];
  assign vtag  = vpage_i[ADDR_W-1:OFF_W+IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o  <= 1'b0;
      ppn_o  <= '0;
      perm_o <= '0;
      ci_o   <= 1'b0;
    end else if (en_i) begin
      hit_o  <= evalid_i && (etag_i == vtag);
      ppn_o  <= eppn_i;
      perm_o <= eperm_i;
      ci_o   <= eci_i;
    end
  end
endmodule

// File: rtl/dtlb_top.sv
module dtlb_top
  import dtlb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned IDX_W = 6,
  parameter logic [31:0] MATCH_BASE = 32'h0000_0A00,
  parameter logic [31:0] XLATE_BASE = 32'h0000_0B00,
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned PPN_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_en_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              sw_o,
  output logic              sr_o,
  output logic              uw_o,
  output logic              ur_o,
  output logic              ci_o,
  input  logic              reg_cs_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  logic             sel_match, sel_xlate, wr_match, wr_xlate;
  logic [IDX_W-1:0] ridx, lidx;
  logic             lvalid, rvalid, lci, rci;
  logic [TAG_W-1:0] ltag, rtag;
  logic [PPN_W-1:0] lppn, rppn;
  perm_t            lperm, rperm, wperm, perm_q;

  dtlb_reg_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .MATCH_BASE(MATCH_BASE), .XLATE_BASE(XLATE_BASE)
  ) u_dec (
    .cs_i(reg_cs_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .sel_match_o(sel_match), .sel_xlate_o(sel_xlate),
    .wr_match_o(wr_match), .wr_xlate_o(wr_xlate), .idx_o(ridx)
  );

  assign wperm = '{sw: reg_wdata_i[SW_BIT], sr: reg_wdata_i[SR_BIT],
                   uw: reg_wdata_i[UW_BIT], ur: reg_wdata_i[UR_BIT]};

  dtlb_entry_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk_i, .rst_ni,
    .wr_match_i(wr_match), .wr_xlate_i(wr_xlate), .widx_i(ridx),
    .wtag_i(reg_wdata_i[31 -: TAG_W]), .wvalid_i(reg_wdata_i[VALID_BIT]),
    .wppn_i(reg_wdata_i[31 -: PPN_W]), .wperm_i(wperm), .wci_i(reg_wdata_i[CI_BIT]),
    .lidx_i(lidx), .lvalid_o(lvalid), .ltag_o(ltag), .lppn_o(lppn),
    .lperm_o(lperm), .lci_o(lci),
    .ridx_i(ridx), .rvalid_o(rvalid), .rtag_o(rtag), .rppn_o(rppn),
    .rperm_o(rperm), .rci_o(rci)
  );

  dtlb_lookup #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_lookup (
    .clk_i, .rst_ni, .en_i(lookup_en_i), .vpage_i(vaddr_i[ADDR_W-1:OFF_W]),
    .idx_o(lidx), .evalid_i(lvalid), .etag_i(ltag), .eppn_i(lppn),
    .eperm_i(lperm), .eci_i(lci),
    .hit_o, .ppn_o, .perm_o(perm_q), .ci_o
  );

  assign sw_o = perm_q.sw;
  assign sr_o = perm_q.sr;
  assign uw_o = perm_q.uw;
  assign ur_o = perm_q.ur;

  // repack stored fields; unstored bits read zero
  always_comb begin
    reg_rdata_o = '0;
    if (sel_match) begin
      reg_rdata_o[31 -: TAG_W]  = rtag;
      reg_rdata_o[VALID_BIT]    = rvalid;
    end else if (sel_xlate) begin
      reg_rdata_o[31 -: PPN_W]  = rppn;
      reg_rdata_o[SW_BIT]       = rperm.sw;
      reg_rdata_o[SR_BIT]       = rperm.sr;
      reg_rdata_o[UW_BIT]       = rperm.uw;
      reg_rdata_o[UR_BIT]       = rperm.ur;
      reg_rdata_o[CI_BIT]       = rci;
    end
  end
endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lookup_en_i,
  input logic        reg_cs_i,
  input logic [31:0] reg_addr_i,
  input logic [31:0] reg_rdata_o,
  input logic        hit_o,
  input logic [18:0] ppn_o,
  input logic        sw_o,
  input logic        sr_o,
  input logic        uw_o,
  input logic        ur_o,
  input logic        ci_o
);
  logic in_win;
  assign in_win = (reg_addr_i[31:6] == 26'h28) || (reg_addr_i[31:6] == 26'h2C);

  a_r6_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_en_i |=> $stable(hit_o) && $stable(ppn_o) && $stable(ci_o)
                     && $stable({sw_o, sr_o, uw_o, ur_o}));

  a_r8_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_cs_i |-> reg_rdata_o == 32'h0);

  a_r7_outside_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_cs_i && !in_win |-> reg_rdata_o == 32'h0);

  a_r2_match_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_cs_i && in_win && !reg_addr_i[8] |-> reg_rdata_o[18:1] == 18'h0);

  a_r3_xlate_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_cs_i && in_win && reg_addr_i[8]
      |-> reg_rdata_o[12:10] == 3'h0 && reg_rdata_o[5:2] == 4'h0 && !reg_rdata_o[0]);
endmodule

bind dtlb_top dtlb_checker chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .lookup_en_i(lookup_en_i),
  .reg_cs_i(reg_cs_i), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .hit_o(hit_o), .ppn_o(ppn_o), .sw_o(sw_o), .sr_o(sr_o),
  .uw_o(uw_o), .ur_o(ur_o), .ci_o(ci_o)
);

// File: tb/dtlb_top_tb.sv
module dtlb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  // virtual address = {tag13, idx6, off13}
  localparam logic [31:0] LK_VA [NV] = '{
    {13'h0AB, 6'd5, 13'h123},
    {13'h1FFF, 6'd63, 13'h1FFF},
    {13'h0AC, 6'd5, 13'h000},
    {13'h000, 6'd0, 13'h000},
    {13'h055, 6'd20, 13'h007},
    {13'h0AB, 6'd6, 13'h000}
  };
  // expected {hit, ppn19, sw, sr, uw, ur, ci}
  localparam logic [24:0] LK_EXP [NV] = '{
    {1'b1, 19'h12345, 4'b1010, 1'b1},
    {1'b1, 19'h7FFFF, 4'b0101, 1'b0},
    {1'b0, 19'h0, 4'b0, 1'b0},
    {1'b0, 19'h0, 4'b0, 1'b0},
    {1'b1, 19'h00ABC, 4'b1111, 1'b0},
    {1'b0, 19'h0, 4'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic lookup_en = 0, cs = 0, we = 0;
  logic [31:0] va = 0, addr = 0, wdata = 0, rdata;
  logic hit, sw, sr, uw, ur, ci;
  logic [18:0] ppn;
  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtlb_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lookup_en_i(lookup_en), .vaddr_i(va),
    .hit_o(hit), .ppn_o(ppn), .sw_o(sw), .sr_o(sr), .uw_o(uw), .ur_o(ur), .ci_o(ci),
    .reg_cs_i(cs), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic reg_rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a;
    #1 d = rdata;
    cs = 0;
  endtask

  task automatic lookup(logic [31:0] v);
    @(negedge clk); lookup_en = 1; va = v;
    @(negedge clk); lookup_en = 0;
  endtask

  function automatic logic [31:0] xl(logic [18:0] p, logic [3:0] pm, logic c);
    return {p, 3'b0, pm, 4'b0, c, 1'b0};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [18:0] hold_ppn;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    lookup({13'h0AB, 6'd5, 13'h0});
    check("R1 miss after reset", 32'(hit), 0);
    reg_rd(32'h0A05, d);
    check("R1 valid clear", 32'(d[0]), 0);

    // program entries (R2, R3)
    reg_wr(32'h0A05, {13'h0AB, 18'h0, 1'b1});
    reg_wr(32'h0B05, xl(19'h12345, 4'b1010, 1'b1));
    reg_wr(32'h0A3F, {13'h1FFF, 18'h0, 1'b1});
    reg_wr(32'h0B3F, xl(19'h7FFFF, 4'b0101, 1'b0));
    reg_wr(32'h0A00, {13'h000, 18'h0, 1'b0});
    reg_wr(32'h0B00, xl(19'h00001, 4'b1111, 1'b1));
    reg_wr(32'h0A14, {13'h055, 18'h0, 1'b1});
    reg_wr(32'h0B14, xl(19'h00ABC, 4'b1111, 1'b0));

    reg_rd(32'h0A05, d);
    check("R2 tag readback", d, {13'h0AB, 18'h0, 1'b1});
    reg_rd(32'h0B05, d);
    check("R3 xlate readback", d, xl(19'h12345, 4'b1010, 1'b1));
    reg_wr(32'h0A0A, 32'hFFFF_FFFF);
    reg_rd(32'h0A0A, d);
    check("R2 unstored bits zero", d, 32'hFFF8_0001);
    reg_wr(32'h0B0A, 32'hFFFF_FFFF);
    reg_rd(32'h0B0A, d);
    check("R3 unstored bits zero", d, 32'hFFFF_E3C2);

    // vector table: R4 / R5 / R9
    for (int k = 0; k < NV; k++) begin
      lookup(LK_VA[k]);
      if (LK_EXP[k][24]) begin
        check("R4 hit", 32'(hit), 1);
        check("R9 ppn", 32'(ppn), 32'(LK_EXP[k][23:5]));
        check("R9 perm", 32'({sw, sr, uw, ur}), 32'(LK_EXP[k][4:1]));
        check("R9 ci", 32'(ci), 32'(LK_EXP[k][0]));
      end else begin
        check("R5 miss", 32'(hit), 0);
      end
    end

    // R6: hold with enable low
    lookup(LK_VA[0]);
    hold_ppn = ppn;
    @(negedge clk); va = LK_VA[2];
    repeat (2) @(negedge clk);
    check("R6 hit held", 32'(hit), 1);
    check("R6 ppn held", 32'(ppn), 32'(hold_ppn));

    // R7: ignored accesses
    reg_wr(32'h0A40, {13'h000, 18'h0, 1'b1});
    lookup({13'h000, 6'd0, 13'h0});
    check("R7 out-of-range write ignored", 32'(hit), 0);
    reg_wr(32'h1A00, {13'h000, 18'h0, 1'b1});
    lookup({13'h000, 6'd0, 13'h0});
    check("R7 upper-bit write ignored", 32'(hit), 0);
    @(negedge clk); cs = 0; we = 1; addr = 32'h0A00; wdata = 32'h1;
    @(negedge clk); we = 0;
    lookup({13'h000, 6'd0, 13'h0});
    check("R7 write without select ignored", 32'(hit), 0);
    reg_rd(32'h0A45, d);
    check("R7 outside read zero", d, 0);
    reg_rd(32'h0C05, d);
    check("R7 other window read zero", d, 0);

    // R8: select low
    @(negedge clk); cs = 0; addr = 32'h0A05;
    #1 check("R8 idle read zero", rdata, 0);

    // R10: write and lookup on the same edge
    @(negedge clk);
    cs = 1; we = 1; addr = 32'h0A1E; wdata = {13'h011, 18'h0, 1'b1};
    lookup_en = 1; va = {13'h011, 6'd30, 13'h0};
    @(negedge clk); cs = 0; we = 0; lookup_en = 0;
    check("R10 old contents seen", 32'(hit), 0);
    lookup({13'h011, 6'd30, 13'h0});
    check("R10 new contents next", 32'(hit), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule